// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns a 21-bit parallel pixel word into three serial data lanes and a forwarded clock lane for a flat-panel display link. Once per pixel period it takes a word made of 18 colour bits and 3 timing bits. Seven bit periods later the word has been shifted out, seven bits on each lane. A fourth lane carries a clock at the pixel rate, and its edges let a receiver find where each pixel period starts.

The block runs on a bit clock at seven times the pixel rate, phase-aligned to the pixel clock. A static select input picks the pixel-clock edge that samples the input word. The select defaults low, which gives falling-edge capture. An active-low power-down input silences every lane and raises an output-enable-low flag. When power-down is released, output starts again at the next pixel-period boundary. Supported pixel rates run from about 20 MHz to 65 MHz, which puts up to 455 Mbit/s on each data lane.

Top module: `px7_serializer`

## Requirements
- R1: The input word is 21 bits wide. Bits 0–5 are red, 6–11 are green and 12–17 are blue. Bit 18 is line sync, bit 19 is frame sync and bit 20 is data enable. Each sent frame carries the whole captured word unchanged.
- R2: Lane 0 carries word bits 0–6, lane 1 carries bits 7–13 and lane 2 carries bits 14–20. Within a frame, the bit-clock cycle after the load edge is slot 0. Slot s of lane l carries word bit 7·l+s.
- R3: While enabled, the clock lane is high in slots 0–3 and low in slots 4–6 of every frame, one full period per pixel period.
- R4: With the edge select high, the word is sampled on the rising pixel-clock edge. With the select low, it is sampled on the falling edge.
- R5: A new word enters the shift registers only at the bit-clock edge that ends slot 6. The frame sent is the word captured during the preceding pixel period. Input changes after the capture edge have no effect, and every captured word is sent exactly once.
- R6: At the first bit-clock edge where power-down is sampled low, all data lanes and the clock lane go to 0 and the enable-low flag goes to 1. They stay in that state while power-down is low.
- R7: After power-down is released, the outputs stay disabled until the next slot-6 boundary. At that boundary they resume with a freshly captured word and the clock lane high.
- R8: During synchronous reset all lanes read 0 and the enable-low flag reads 1. The first bit-clock edge after reset is a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset (bit_clk domain) |
| pix_clk | input | 1 | Pixel clock, phase-aligned to bit_clk |
| pix_word_i | input | 21 | Parallel pixel word (colour and timing bits) |
| edge_sel_i | input | 1 | 1: capture on rising pix_clk edge; 0 (default): falling edge |
| pd_n_i | input | 1 | Active-low power-down |
| ser_d_o | output | 3 | Serial data lanes, one bit per lane per bit clock |
| ser_clk_o | output | 1 | Forwarded clock lane |
| oe_n_o | output | 1 | High while outputs are disabled |

## Verification
The bench deserializes every frame by locking onto the clock-lane rising edge. It changes the input word between the rising and falling pixel edges and again after both. A design that sampled on the wrong edge, or that loaded at any point other than the slot-6 boundary, would therefore send a value that is visibly wrong. A walking-one sweep exposes any swap of lane order or slot order. A power-down window checks three things: output stops on the very next edge, output stays off after release until the frame boundary, and the first frame after release is the word just captured rather than a stale one. A count of expected frames against recovered frames catches a clock lane with a broken pattern, which would otherwise hide frames from the monitor.

// File: rtl/px7_pkg.sv
package px7_pkg;
  localparam int unsigned PX7_LANES  = 3;
  localparam int unsigned PX7_SLOTS  = 7;
  localparam int unsigned PX7_CLK_HI = 4;
endpackage

// File: rtl/px7_capture.sv
// Pixel-clock capture on both edges; the static select chooses which copy feeds the shifters.
module px7_capture #(
  parameter int unsigned W = 21
) (
  input  logic         pix_clk,
  input  logic         edge_sel_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] cap_rise_q;
  logic [W-1:0] cap_fall_q;

  always_ff @(posedge pix_clk) cap_rise_q <= word_i;
  always_ff @(negedge pix_clk) cap_fall_q <= word_i;

  assign word_o = edge_sel_i ? cap_rise_q : cap_fall_q;
endmodule

// File: rtl/px7_slot_ctr.sv
// Free-running slot counter; resets to the last slot so the first edge after reset is a boundary.
module px7_slot_ctr #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned SW   = $clog2(SLOTS)
) (
  input  logic          bit_clk,
  input  logic          rst,
  output logic [SW-1:0] slot_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  always_ff @(posedge bit_clk) begin
    if (rst)                 slot_o <= LAST;
    else if (slot_o == LAST) slot_o <= '0;
    else                     slot_o <= slot_o + 1'b1;
  end

  assign wrap_o = (slot_o == LAST);
endmodule

// File: rtl/px7_lane_shift.sv
// One data lane: parallel load at the boundary, LSB first, cleared on power-down.
module px7_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             bit_clk,
  input  logic             rst,
  input  logic             kill_i,
  input  logic             load_i,
  input  logic [SLOTS-1:0] bits_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge bit_clk) begin
    if (rst || kill_i) sh_q <= '0;
    else if (load_i)   sh_q <= bits_i;
    else               sh_q <= sh_q >> 1;
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/px7_serializer.sv
module px7_serializer #(
  parameter int unsigned LANES  = px7_pkg::PX7_LANES,
  parameter int unsigned SLOTS  = px7_pkg::PX7_SLOTS,
  parameter int unsigned CLK_HI = px7_pkg::PX7_CLK_HI,
  localparam int unsigned WORD_W = LANES * SLOTS,
  localparam int unsigned SW     = $clog2(SLOTS)
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] pix_word_i,
  input  logic              edge_sel_i,
  input  logic              pd_n_i,
  output logic [LANES-1:0]  ser_d_o,
  output logic              ser_clk_o,
  output logic              oe_n_o
);
  logic [WORD_W-1:0] word;
  logic [SW-1:0]     slot;
  logic              wrap;
  logic              load;
  logic              live_q;
  logic              clk_q;
  logic [SW:0]       slot_nx;

  px7_capture #(.W(WORD_W)) cap_i (
    .pix_clk    (pix_clk),
    .edge_sel_i (edge_sel_i),
    .word_i     (pix_word_i),
    .word_o     (word)
  );

  px7_slot_ctr #(.SLOTS(SLOTS)) ctr_i (
    .bit_clk (bit_clk),
    .rst     (rst),
    .slot_o  (slot),
    .wrap_o  (wrap)
  );

  assign load = wrap && pd_n_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    px7_lane_shift #(.SLOTS(SLOTS)) lane_i (
      .bit_clk (bit_clk),
      .rst     (rst),
      .kill_i  (!pd_n_i),
      .load_i  (load),
      .bits_i  (word[g*SLOTS +: SLOTS]),
      .ser_o   (ser_d_o[g])
    );
  end

  // Clock lane value for the slot that follows this edge.
  assign slot_nx = {1'b0, slot} + 1'b1;

  always_ff @(posedge bit_clk) begin
    if (rst || !pd_n_i) begin
      live_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (wrap) begin
      live_q <= 1'b1;
      clk_q  <= 1'b1;
    end else begin
      clk_q  <= live_q && (slot_nx < (SW+1)'(CLK_HI));
    end
  end

  assign ser_clk_o = clk_q;
  assign oe_n_o    = !live_q;
endmodule

module px7_serializer_chk #(
  parameter int unsigned LANES = 3
) (
  input logic             bit_clk,
  input logic             rst,
  input logic             pd_n_i,
  input logic [LANES-1:0] ser_d_o,
  input logic             ser_clk_o,
  input logic             oe_n_o
);
  // R6: power-down silences everything on the next edge
  a_r6_pd_quiet: assert property (@(posedge bit_clk) disable iff (rst)
    !pd_n_i |=> (ser_d_o == '0 && !ser_clk_o && oe_n_o));

  // R6: while disabled, no lane toggles
  a_r6_off_silent: assert property (@(posedge bit_clk) disable iff (rst)
    oe_n_o |-> (ser_d_o == '0 && !ser_clk_o));

  // R7: enabling only happens together with a clock-lane rise (frame start)
  a_r7_wake_at_boundary: assert property (@(posedge bit_clk) disable iff (rst)
    $fell(oe_n_o) |-> ser_clk_o);

  // R3: high phase lasts more than one slot
  a_r3_clk_high_run: assert property (@(posedge bit_clk) disable iff (rst)
    ($rose(ser_clk_o) && pd_n_i) |=> ser_clk_o);

  // R3: low phase lasts more than one slot while running
  a_r3_clk_low_run: assert property (@(posedge bit_clk) disable iff (rst)
    ($fell(ser_clk_o) && !oe_n_o && pd_n_i) |=> !ser_clk_o);
endmodule

bind px7_serializer px7_serializer_chk #(.LANES(LANES)) chk_i (
  .bit_clk   (bit_clk),
  .rst       (rst),
  .pd_n_i    (pd_n_i),
  .ser_d_o   (ser_d_o),
  .ser_clk_o (ser_clk_o),
  .oe_n_o    (oe_n_o)
);

// File: tb/px7_serializer_tb_top.sv
`timescale 1ns/1ps
module px7_serializer_tb_top;
  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;

  logic bit_clk = 1'b0;
  logic rst = 1'b1;
  logic pix_clk = 1'b0;
  logic edge_sel = 1'b1;
  logic pd_n = 1'b1;
  logic [W-1:0] word = '0;
  logic [LANES-1:0] ser_d;
  logic ser_clk;
  logic oe_n;

  int checks = 0;
  int fails  = 0;
  bit pd_window = 1'b0;
  bit mon_en = 1'b1;
  logic [W:0] exp_q[$];   // {care, word}

  always #4 bit_clk = ~bit_clk;   // 125 MHz bit clock

  px7_serializer dut_i (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .pix_clk    (pix_clk),
    .pix_word_i (word),
    .edge_sel_i (edge_sel),
    .pd_n_i     (pd_n),
    .ser_d_o    (ser_d),
    .ser_clk_o  (ser_clk),
    .oe_n_o     (oe_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One pixel period: a before the rising edge, b before the falling edge, c after both.
  // kind 0: frame never appears; 1: frame appears, not checked; 2: frame checked.
  task automatic drive_px(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                          input logic sel, input logic pdv, input int kind);
    @(posedge bit_clk);
    #1 word = a; edge_sel = sel; pd_n = pdv;
    if (kind == 1) exp_q.push_back({1'b0, {W{1'b0}}});
    else if (kind == 2) exp_q.push_back({1'b1, sel ? a : b});
    #1  pix_clk = 1'b1;
    #14 word = b;
    #14 pix_clk = 1'b0;
    #6  word = c;
    repeat (2) @(posedge bit_clk);
  endtask

  // Monitor: deserialize using the clock-lane rise as frame start.
  int fpos = -1;
  logic prev_clk = 1'b0;
  logic [SLOTS-1:0] cpat;
  logic [W-1:0] got;
  logic [W:0] e;

  always @(negedge bit_clk) begin
    if (mon_en) begin
      if (fpos < 0 && prev_clk == 1'b0 && ser_clk == 1'b1) fpos = 0;
      if (fpos >= 0) begin
        cpat[fpos] = ser_clk;
        for (int l = 0; l < LANES; l++) got[l*SLOTS + fpos] = ser_d[l];
        fpos++;
        if (fpos == SLOTS) begin
          fpos = -1;
          if (!pd_window) chk(cpat == 7'b0001111, "R3 clock lane pattern", 32'(cpat), 32'h0F);
          if (cpat == 7'b0001111) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame", 32'(got), 32'h0);
            else begin
              e = exp_q.pop_front();
              if (e[W]) chk(got === e[W-1:0], "R1 R2 R4 R5 recovered word", 32'(got), 32'(e[W-1:0]));
            end
          end
        end
      end
      prev_clk = ser_clk;
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    exp_q.push_back('0);   // frame sent at the first boundary carries no driven word
    repeat (3) @(posedge bit_clk);
    #2;
    chk(ser_d == '0, "R8 lanes low in reset", 32'(ser_d), 32'h0);
    chk(ser_clk == 1'b0, "R8 clock lane low in reset", 32'(ser_clk), 32'h0);
    chk(oe_n == 1'b1, "R8 outputs disabled in reset", 32'(oe_n), 32'h1);
    @(negedge bit_clk);
    rst = 1'b0;

    drive_px('0, '0, '0, 1'b1, 1'b1, 1);

    // Rising-edge capture
    drive_px(21'h1FFFFF, 21'h000000, 21'h0F0F0F, 1'b1, 1'b1, 2);
    drive_px(21'h155555, 21'h0AAAAA, 21'h000000, 1'b1, 1'b1, 2);
    for (int i = 0; i < W; i++)
      drive_px(W'(1) << i, ~(W'(1) << i), 21'h1FFFFF, 1'b1, 1'b1, 2);

    // Falling-edge capture
    drive_px(21'h000000, 21'h1FFFFF, 21'h012345, 1'b0, 1'b1, 2);
    drive_px(21'h0AAAAA, 21'h155555, 21'h000000, 1'b0, 1'b1, 2);
    for (int i = 0; i < 8; i++)
      drive_px(W'(i*37 + 5), W'(i*32'h2F1B3 + 32'h0C0DE), W'(i), 1'b0, 1'b1, 2);

    // Power-down window
    #2 pd_window = 1'b1;
    drive_px(21'h0ABCDE, 21'h0, 21'h0, 1'b1, 1'b1, 0);   // frame cut short by power-down
    drive_px(21'h111111, 21'h0, 21'h0, 1'b1, 1'b0, 0);
    #2;
    chk(ser_d == '0, "R6 lanes forced low", 32'(ser_d), 32'h0);
    chk(ser_clk == 1'b0, "R6 clock lane forced low", 32'(ser_clk), 32'h0);
    chk(oe_n == 1'b1, "R6 enable-low flag raised", 32'(oe_n), 32'h1);
    drive_px(21'h0F00F0, 21'h0, 21'h0, 1'b1, 1'b0, 0);
    #2;
    chk(ser_d == '0, "R6 lanes stay low", 32'(ser_d), 32'h0);
    chk(oe_n == 1'b1, "R6 flag stays raised", 32'(oe_n), 32'h1);
    drive_px(21'h13579B, 21'h02468A, 21'h0, 1'b1, 1'b1, 2);
    #2;
    chk(oe_n == 1'b1, "R7 still disabled before boundary", 32'(oe_n), 32'h1);
    chk(ser_clk == 1'b0, "R7 clock lane quiet before boundary", 32'(ser_clk), 32'h0);
    drive_px(21'h1C3C3C, 21'h0, 21'h0, 1'b1, 1'b1, 2);
    #2;
    chk(oe_n == 1'b0, "R7 enabled after boundary", 32'(oe_n), 32'h0);
    drive_px(21'h0C0FFE, 21'h1, 21'h2, 1'b1, 1'b1, 2);
    #2 pd_window = 1'b0;

    drive_px(21'h0D00D0, 21'h0, 21'h1FFFFF, 1'b1, 1'b1, 2);
    drive_px('0, '0, '0, 1'b1, 1'b1, 1);
    drive_px('0, '0, '0, 1'b1, 1'b1, 1);
    repeat (SLOTS + 1) @(posedge bit_clk);
    #2;
    mon_en = 1'b0;
    chk(exp_q.size() == 0, "R3 R5 every expected frame recovered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule